// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block is the command interpreter of a NOR-style flash device, reduced to the sector erase path. It watches a write bus made of an address, a data byte and a one-cycle write strobe, and it recognises a six-write command sequence that ends in a sector erase command. That final write opens a timed accept window. Inside the window, further writes of the sector erase command queue more sectors into a pending bitmap, and each one restarts the window. When the window runs out, a simulated embedded erase starts. It is a cycle counter that, on completion, marks every queued sector as erased.

Reads share the address bus. In array mode a read returns FFh for an erased sector and 00h for any other sector. While the window is open or the erase runs, a read returns a status byte with polling and toggle bits. A ready/busy output is low while the erase is in progress. The window length and the erase duration are parameters given in clock cycles, so a bench can shorten both.

Top module: `flash_erase_seq`

## Requirements
- R1: The writes (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h) and then any address with data 30h, each on one write cycle, open the accept window. The unlock and setup addresses are compared on address bits 11:0, and the sector is address bits 14:12.
- R2: A write during the six-write entry that does not match the next expected step returns the machine to array mode, and no erase follows.
- R3: A write of data 30h inside the window adds the sector in address bits 14:12 to the pending set, so any number of sectors from one to all can be queued in any order.
- R4: The window closes WIN_CYC cycles after the most recent sector write. Each sector write restarts it, and ready goes low on the clock edge WIN_CYC cycles after that write.
- R5: Inside the window, a write whose data is neither 30h nor B0h discards all pending sectors and returns to array mode, and no erase follows.
- R6: Ready stays low for exactly ERASE_CYC cycles from the close of the window and then returns high.
- R7: While the erase runs, every write except data B0h is ignored: the erase completes on schedule and no sector is added.
- R8: A write of data B0h inside the window or during the erase halts the operation. Ready stays high, no pending sector is marked erased, reads return array data, and the state holds until reset.
- R9: In the window and during the erase a read returns a status byte: bit 7 is 0, bit 6 inverts after every read, bit 3 is 0 in the window and 1 during the erase, bit 2 inverts only after a read whose sector is pending, and bits 5, 4, 1 and 0 are 0.
- R10: After reset, ready is high and every sector reads 00h. After a completed erase, the erased sectors read FFh and all others still read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W (15) | Byte address shared by writes and reads; bits 14:12 select the sector |
| wdata | input | 8 | Write data (command byte) |
| rd_en | input | 1 | Read strobe; toggle bits advance on the edge where it is high |
| rd_data | output | 8 | Array data or status byte for the current address |
| ready | output | 1 | High when no embedded erase is running |

## Verification
The hardest situation to reach is a window kept open by restarts for longer than one window length. To show it, the last sector has to be proven still queueable after the first window would have expired, and the erase has to be shown to start on the exact edge set by the final restart. The bench keeps every stimulus aligned to the falling edge. It spaces sector writes a few cycles short of the window length, so that their combined span exceeds it, and then samples ready on the cycles just before and just after the expected close. It reaches the erase-ignore and suspend cases in the same way. It counts cycles from the close of the window, injects foreign commands mid-erase, and then checks the completion edge exactly.

// File: rtl/fes_pkg.sv
// Package: shared types for the flash sector erase sequencer.
// Assumes: command bytes and unlock addresses are fixed by the device protocol.
package fes_pkg;

    // Classified meaning of one bus write
    typedef enum logic [2:0] {
        CMD_OTHER = 3'd0,
        CMD_UNLK1 = 3'd1,
        CMD_UNLK2 = 3'd2,
        CMD_SETUP = 3'd3,
        CMD_SECT  = 3'd4,
        CMD_SUSP  = 3'd5
    } fes_cmd_e;

    // Command interpreter states
    typedef enum logic [3:0] {
        ST_READ  = 4'd0,
        ST_U1    = 4'd1,
        ST_U2    = 4'd2,
        ST_SETUP = 4'd3,
        ST_U3    = 4'd4,
        ST_U4    = 4'd5,
        ST_WIN   = 4'd6,
        ST_ERS   = 4'd7,
        ST_SUSP  = 4'd8
    } fes_state_e;

    localparam logic [7:0] BYTE_UNLK1 = 8'hAA;
    localparam logic [7:0] BYTE_UNLK2 = 8'h55;
    localparam logic [7:0] BYTE_SETUP = 8'h80;
    localparam logic [7:0] BYTE_SECT  = 8'h30;
    localparam logic [7:0] BYTE_SUSP  = 8'hB0;

endpackage

// File: rtl/fes_cmd_decode.sv
// Module: fes_cmd_decode
// Classifies a write (low address bits plus data byte) into a command kind.
// Assumes: unlock addresses are matched on the low CMD_AW address bits only;
// the sector erase and suspend bytes are accepted at any address.
module fes_cmd_decode
    import fes_pkg::*;
#(
    parameter int CMD_AW = 12
) (
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output fes_cmd_e          cmd_kind
);
    localparam logic [CMD_AW-1:0] ADR_A = CMD_AW'(12'h555);
    localparam logic [CMD_AW-1:0] ADR_B = CMD_AW'(12'h2AA);

    // Decode the write into one command kind
    always_comb begin
        cmd_kind = CMD_OTHER;
        if (cmd_data == BYTE_SECT)                               cmd_kind = CMD_SECT;
        else if (cmd_data == BYTE_SUSP)                          cmd_kind = CMD_SUSP;
        else if (cmd_addr == ADR_A && cmd_data == BYTE_UNLK1)    cmd_kind = CMD_UNLK1;
        else if (cmd_addr == ADR_B && cmd_data == BYTE_UNLK2)    cmd_kind = CMD_UNLK2;
        else if (cmd_addr == ADR_A && cmd_data == BYTE_SETUP)    cmd_kind = CMD_SETUP;
    end

endmodule

// File: rtl/fes_timer.sv
// Module: fes_timer
// Single down-counter shared by the accept window and the embedded erase.
// A load starts a run; expire is high in the last cycle of a run, so the
// consumer acts exactly WIN_CYC (or ERS_CYC) edges after the load edge.
// Assumes: both lengths are at least 1; load takes priority over stop.
module fes_timer #(
    parameter int WIN_CYC = 10000,
    parameter int ERS_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_win,
    input  logic ld_ers,
    input  logic stop,
    output logic expire
);
    localparam int MAX_CYC = (WIN_CYC > ERS_CYC) ? WIN_CYC : ERS_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             active;

    // Load, count down, or stop the shared counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (ld_win) begin
            cnt    <= CNT_W'(WIN_CYC);
            active <= 1'b1;
        end else if (ld_ers) begin
            cnt    <= CNT_W'(ERS_CYC);
            active <= 1'b1;
        end else if (stop) begin
            active <= 1'b0;
        end else if (active) begin
            if (cnt == CNT_W'(1)) active <= 1'b0;
            else                  cnt    <= cnt - 1'b1;
        end
    end

    assign expire = active && (cnt == CNT_W'(1));

    // R4: a running count never reaches zero
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != '0));

    // R4: a window load starts a full-length run
    win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_win |=> (active && cnt == CNT_W'(WIN_CYC)));

endmodule

// File: rtl/fes_sector_map.sv
// Module: fes_sector_map
// Holds the pending-erase bitmap and the per-sector erased flags.
// Assumes: erased flags are only cleared by reset (no program path).
module fes_sector_map #(
    parameter int SEC_BITS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   q_add,
    input  logic [SEC_BITS-1:0]    q_sec,
    input  logic                   q_clear,
    input  logic                   commit,
    output logic [(1<<SEC_BITS)-1:0] pending,
    output logic [(1<<SEC_BITS)-1:0] erased
);
    localparam int NSEC = 1 << SEC_BITS;

    // Update the pending set: add, discard, or hand over on completion
    always_ff @(posedge clk) begin
        if (!rst_n)                pending <= '0;
        else if (q_clear || commit) pending <= '0;
        else if (q_add)            pending[q_sec] <= 1'b1;
    end

    // Mark queued sectors as erased when the embedded erase completes
    always_ff @(posedge clk) begin
        if (!rst_n)      erased <= '0;
        else if (commit) erased <= erased | pending;
    end

    // R3: a queued sector is pending on the next cycle
    q_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_add && !q_clear && !commit) |=> pending[$past(q_sec)]);

    // R10: an erased flag never falls back
    erased_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((erased & $past(erased)) == $past(erased)) || $past(!rst_n));

    // R5: discarding empties the whole set
    q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_clear |=> (pending == NSEC'(0)));

endmodule

// File: rtl/fes_ctrl_fsm.sv
// Module: fes_ctrl_fsm
// Command interpreter: walks the six-write entry, runs the accept window,
// starts and supervises the embedded erase, and handles suspend.
// Assumes: wr_en is a one-cycle strobe; a write in the same cycle as a window
// expiry wins over the expiry.
module fes_ctrl_fsm
    import fes_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  fes_cmd_e   cmd,
    input  logic       expire,
    output fes_state_e state,
    output logic       ld_win,
    output logic       ld_ers,
    output logic       t_stop,
    output logic       q_add,
    output logic       q_clear,
    output logic       commit
);
    fes_state_e nxt;

    // Next state and control strobes
    always_comb begin
        nxt     = state;
        ld_win  = 1'b0;
        ld_ers  = 1'b0;
        t_stop  = 1'b0;
        q_add   = 1'b0;
        q_clear = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_READ:  if (wr_en && cmd == CMD_UNLK1) nxt = ST_U1;
            ST_U1:    if (wr_en) nxt = (cmd == CMD_UNLK2) ? ST_U2    : ST_READ;
            ST_U2:    if (wr_en) nxt = (cmd == CMD_SETUP) ? ST_SETUP : ST_READ;
            ST_SETUP: if (wr_en) nxt = (cmd == CMD_UNLK1) ? ST_U3    : ST_READ;
            ST_U3:    if (wr_en) nxt = (cmd == CMD_UNLK2) ? ST_U4    : ST_READ;
            ST_U4: begin
                if (wr_en) begin
                    if (cmd == CMD_SECT) begin
                        nxt    = ST_WIN;
                        q_add  = 1'b1;
                        ld_win = 1'b1;
                    end else begin
                        nxt = ST_READ;
                    end
                end
            end
            ST_WIN: begin
                if (wr_en) begin
                    if (cmd == CMD_SECT) begin
                        q_add  = 1'b1;
                        ld_win = 1'b1;
                    end else if (cmd == CMD_SUSP) begin
                        nxt    = ST_SUSP;
                        t_stop = 1'b1;
                    end else begin
                        nxt     = ST_READ;
                        q_clear = 1'b1;
                        t_stop  = 1'b1;
                    end
                end else if (expire) begin
                    nxt    = ST_ERS;
                    ld_ers = 1'b1;
                end
            end
            ST_ERS: begin
                if (wr_en && cmd == CMD_SUSP) begin
                    nxt    = ST_SUSP;
                    t_stop = 1'b1;
                end else if (expire) begin
                    nxt    = ST_READ;
                    commit = 1'b1;
                end
            end
            ST_SUSP:  nxt = ST_SUSP;
            default:  nxt = ST_READ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    // R2: a wrong second entry write falls back to array mode
    entry_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_U1 && wr_en && cmd != CMD_UNLK2) |=> (state == ST_READ));

    // R5: a stray write inside the window aborts
    stray_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN && wr_en && cmd != CMD_SECT && cmd != CMD_SUSP)
        |=> (state == ST_READ));

    // R7: foreign writes during the erase leave it running
    erase_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS && wr_en && cmd != CMD_SUSP && !expire) |=> (state == ST_ERS));

    // R8: a suspended machine stays suspended
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP) |=> (state == ST_SUSP));

endmodule

// File: rtl/flash_erase_seq.sv
// Module: flash_erase_seq (top)
// Sector erase command sequencer: decodes bus writes, queues sectors during
// the accept window, runs a counted embedded erase and serves array or
// status reads. Assumes: address = {sector, command offset}; writes and
// reads are one-cycle strobes; rd_data is combinational from addr.
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int SEC_BITS  = 3,
    parameter int CMD_AW    = 12,
    parameter int ADDR_W    = CMD_AW + SEC_BITS,
    parameter int WIN_CYC   = 10000,
    parameter int ERASE_CYC = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              ready
);
    localparam int NSEC = 1 << SEC_BITS;

    fes_cmd_e            cmd;
    fes_state_e          state;
    logic                ld_win, ld_ers, t_stop, expire;
    logic                q_add, q_clear, commit;
    logic [NSEC-1:0]     pending, erased;
    logic [SEC_BITS-1:0] sec;
    logic                busy_view;
    logic                tog6, tog2;

    assign sec = addr[ADDR_W-1 -: SEC_BITS];

    fes_cmd_decode #(.CMD_AW(CMD_AW)) u_dec (
        .cmd_addr (addr[CMD_AW-1:0]),
        .cmd_data (wdata),
        .cmd_kind (cmd)
    );

    fes_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .cmd     (cmd),
        .expire  (expire),
        .state   (state),
        .ld_win  (ld_win),
        .ld_ers  (ld_ers),
        .t_stop  (t_stop),
        .q_add   (q_add),
        .q_clear (q_clear),
        .commit  (commit)
    );

    fes_timer #(.WIN_CYC(WIN_CYC), .ERS_CYC(ERASE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_win (ld_win),
        .ld_ers (ld_ers),
        .stop   (t_stop),
        .expire (expire)
    );

    fes_sector_map #(.SEC_BITS(SEC_BITS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_add   (q_add),
        .q_sec   (sec),
        .q_clear (q_clear),
        .commit  (commit),
        .pending (pending),
        .erased  (erased)
    );

    assign busy_view = (state == ST_WIN) || (state == ST_ERS);
    assign ready     = (state != ST_ERS);

    // Advance the toggle bits on each status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else if (rd_en && busy_view) begin
            tog6 <= ~tog6;
            if (pending[sec]) tog2 <= ~tog2;
        end
    end

    // Select status byte or array data for the addressed sector
    always_comb begin
        if (busy_view) rd_data = {1'b0, tog6, 2'b00, (state == ST_ERS), tog2, 2'b00};
        else           rd_data = erased[sec] ? 8'hFF : 8'h00;
    end

    // R4: a sector write in the window keeps it open and ready high
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN && wr_en && cmd == CMD_SECT) |=> (state == ST_WIN && ready));

    // R9: a read while busy reports bit 7 low and bit 3 high
    busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && rd_en) |-> (rd_data[7] == 1'b0 && rd_data[3] == 1'b1));

    // R9: each status read inverts bit 6
    poll_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_view && rd_en) |=> (tog6 != $past(tog6)));

    // R6: the pending set is frozen while the erase runs
    ers_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS && !expire) |=> $stable(pending));

endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb;
    localparam int SB  = 3;
    localparam int CAW = 12;
    localparam int AW  = CAW + SB;
    localparam int W   = 40;
    localparam int E   = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          ready;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    flash_erase_seq #(.SEC_BITS(SB), .CMD_AW(CAW), .WIN_CYC(W), .ERASE_CYC(E)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .rd_data(rd_data), .ready(ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int s, output logic [7:0] d);
        addr = {SB'(s), CAW'(0)}; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [AW-1:0] sa(input int s);
        return {SB'(s), CAW'(0)};
    endfunction

    task automatic entry(input int s);
        wr(AW'(12'h555), 8'hAA);
        wr(AW'(12'h2AA), 8'h55);
        wr(AW'(12'h555), 8'h80);
        wr(AW'(12'h555), 8'hAA);
        wr(AW'(12'h2AA), 8'h55);
        wr(sa(s), 8'h30);
    endtask

    task automatic wait_ready(input logic v, input int lim);
        for (int i = 0; i < lim && ready !== v; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R10 ready after reset", {7'd0, ready}, 8'h01);
        for (int s = 0; s < 8; s++) begin
            rd(s, d);
            chk("R10 sector reads 00 after reset", d, 8'h00);
        end
    endtask

    task automatic t_single();
        logic [7:0] a, b;
        do_reset();
        entry(2);
        rd(2, a); rd(2, b);
        chk("R1 window status bits 7,3 low", a & 8'h88, 8'h00);
        chk("R9 unused status bits zero", a & 8'h33, {4'd0, a[2], 3'd0} & 8'h33);
        chk("R9 bit6 toggles", {7'd0, b[6]}, {7'd0, ~a[6]});
        chk("R9 bit2 toggles on queued sector", {7'd0, b[2]}, {7'd0, ~a[2]});
        rd(5, a); rd(5, b);
        chk("R9 bit2 steady on idle sector", {7'd0, b[2]}, {7'd0, a[2]});
        wait_ready(1'b0, W + 5);
        chk("R6 busy after window", {7'd0, ready}, 8'h00);
        rd(2, a);
        chk("R9 erase status bit3 high bit7 low", a & 8'h88, 8'h08);
        wait_ready(1'b1, E + 5);
        rd(2, a);
        chk("R10 erased sector reads FF", a, 8'hFF);
        rd(5, a);
        chk("R10 other sector reads 00", a, 8'h00);
    endtask

    task automatic t_multi_restart();
        logic [7:0] d;
        do_reset();
        entry(1);
        repeat (W - 5) @(negedge clk);
        wr(sa(4), 8'h30);
        repeat (W - 5) @(negedge clk);
        chk("R4 window kept open by restart", {7'd0, ready}, 8'h01);
        wr(sa(6), 8'h30);
        repeat (W - 1) @(negedge clk);
        chk("R4 still ready one cycle before close", {7'd0, ready}, 8'h01);
        @(negedge clk);
        chk("R4 busy exactly at close", {7'd0, ready}, 8'h00);
        repeat (E - 1) @(negedge clk);
        chk("R6 busy through last erase cycle", {7'd0, ready}, 8'h00);
        @(negedge clk);
        chk("R6 ready after erase length", {7'd0, ready}, 8'h01);
        for (int s = 0; s < 8; s++) begin
            rd(s, d);
            chk("R3 queued sectors erased", d, (s == 1 || s == 4 || s == 6) ? 8'hFF : 8'h00);
        end
    endtask

    task automatic t_bad_entry();
        logic [7:0] d;
        do_reset();
        wr(AW'(12'h555), 8'hAA);
        wr(AW'(12'h2AA), 8'h55);
        wr(AW'(12'h555), 8'h90);
        wr(AW'(12'h555), 8'hAA);
        wr(AW'(12'h2AA), 8'h55);
        wr(sa(3), 8'h30);
        repeat (W + 2) @(negedge clk);
        chk("R2 no erase after broken entry", {7'd0, ready}, 8'h01);
        repeat (E) @(negedge clk);
        rd(3, d);
        chk("R2 sector untouched", d, 8'h00);
    endtask

    task automatic t_stray();
        logic [7:0] d;
        do_reset();
        entry(3);
        wr(sa(5), 8'h30);
        wr(AW'(12'h555), 8'hF0);
        repeat (W + 2) @(negedge clk);
        chk("R5 stray write aborts, no erase", {7'd0, ready}, 8'h01);
        entry(7);
        wait_ready(1'b0, W + 5);
        wait_ready(1'b1, E + 5);
        rd(3, d); chk("R5 discarded sector 3 not erased", d, 8'h00);
        rd(5, d); chk("R5 discarded sector 5 not erased", d, 8'h00);
        rd(7, d); chk("R1 new sequence erases sector 7", d, 8'hFF);
    endtask

    task automatic t_erase_ignore();
        logic [7:0] d;
        do_reset();
        entry(0);
        repeat (W) @(negedge clk);
        chk("R7 erase started", {7'd0, ready}, 8'h00);
        wr(AW'(12'h555), 8'hF0);
        wr(AW'(12'h555), 8'hAA);
        wr(sa(1), 8'h30);
        repeat (E - 4) @(negedge clk);
        chk("R7 foreign writes ignored, still busy", {7'd0, ready}, 8'h00);
        @(negedge clk);
        chk("R7 erase ends on schedule", {7'd0, ready}, 8'h01);
        rd(0, d); chk("R7 sector 0 erased", d, 8'hFF);
        rd(1, d); chk("R7 sector written during erase not added", d, 8'h00);
    endtask

    task automatic t_suspend();
        logic [7:0] d;
        do_reset();
        entry(2);
        repeat (W) @(negedge clk);
        wr(sa(2), 8'hB0);
        chk("R8 suspend in erase raises ready", {7'd0, ready}, 8'h01);
        repeat (E + 5) @(negedge clk);
        chk("R8 stays suspended", {7'd0, ready}, 8'h01);
        rd(2, d); chk("R8 suspended sector not erased", d, 8'h00);
        do_reset();
        entry(4);
        wr(sa(4), 8'hB0);
        repeat (W + 2) @(negedge clk);
        chk("R8 suspend in window, no erase", {7'd0, ready}, 8'h01);
        rd(4, d); chk("R8 window-suspended sector not erased", d, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_multi_restart();
        t_bad_entry();
        t_stray();
        t_erase_ignore();
        t_suspend();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule